// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block sits behind an MDIO slave front end and turns clause-22 style register accesses into 32-bit reads and writes on an internal register bus. The front end has already decoded the serial frames. Each access reaches the bridge as a one-cycle transaction that carries a PHY address, a register number, a write flag and 16 bits of write data.

A 32-bit word is addressed by a 16-bit word index. The index is split three ways:
- a 9-bit page register, loaded through a dedicated PHY/register pair, supplies index bits 15:7;
- the low three bits of the PHY address supply bits 6:4;
- bits 4:1 of the register number supply bits 3:0.

Each word appears as an even/odd register pair. The even register carries bits 15:0 and the odd register carries bits 31:16.

Software writes the odd half first and the even half second, and the even write commits the whole word in a single bus cycle. Software reads the even half first. That read fetches the whole word and keeps its upper half, so the following odd read returns data that is coherent with the lower half.

Top module: `mdio_regbridge`

## Requirements
- R1: After reset the page register is 0, `rsp_valid` is 0, and `bus_req` is 0 while no transaction is offered.
- R2: A write to PHY 0x1F, register 0x10 loads the page register from write-data bits 8:0, and the upper write-data bits are dropped. This access causes no bus cycle and no response.
- R3: For PHY addresses 0x10 to 0x17, the bus word address is {page, phy[2:0], reg[4:1]}, and it is driven in the same cycle as the transaction.
- R4: A write to an odd register in the window only stages its 16 bits as the upper half. It makes no bus cycle.
- R5: A write to an even register in the window makes one bus write in the transaction cycle. The bus data is {staged upper half, write data}.
- R6: A read of an even register in the window makes one bus read in the transaction cycle. One cycle later `rsp_valid` is 1 and `rsp_data` holds bus-data bits 15:0.
- R7: A read of an odd register in the window makes no bus cycle. One cycle later it returns the bits 31:16 captured by the most recent even read, even if the word has changed on the bus since then.
- R8: A transaction to a PHY address outside 0x10 to 0x17 and other than 0x1F makes no bus cycle and no response. It changes no state.
- R9: A read of PHY 0x1F, register 0x10 responds one cycle later with the page value, zero-extended to 16 bits. It makes no bus cycle.
- R10: Accesses to PHY 0x1F at any register other than 0x10 are ignored. They leave the page unchanged and produce no response.
- R11: The staged upper half is not cleared by a commit. Later even writes with no new odd write reuse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txn_valid | input | 1 | One-cycle decoded MDIO transaction strobe |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_phy | input | 5 | PHY address of the transaction |
| txn_reg | input | 5 | Register number of the transaction |
| txn_wdata | input | 16 | Write data of the transaction |
| rsp_valid | output | 1 | Read response strobe, one cycle after a read |
| rsp_data | output | 16 | Read response data |
| bus_req | output | 1 | Internal bus access strobe |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 16 | Internal bus word index |
| bus_wdata | output | 32 | Internal bus write data |
| bus_rdata | input | 32 | Internal bus read data, valid in the access cycle |

## Verification
The checks assume that the serial front end offers at most one transaction per cycle and never offers one while the internal reset is still held. They also assume that `bus_rdata` is a combinational function of `bus_addr` within the access cycle. The stimulus holds `txn_valid` low through reset and for several cycles after it. Every transaction lasts exactly one cycle and is followed by an idle cycle. The bench register file answers reads combinationally, and the bench changes it only in the idle gaps between transactions.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PAGE_WR,
    ACC_PAGE_RD,
    ACC_HI_WR,
    ACC_LO_WR,
    ACC_HI_RD,
    ACC_LO_RD
  } acc_e;
endpackage

// File: rtl/mdb_decode.sv
module mdb_decode
  import mdb_pkg::*;
#(
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  parameter int WIN_LO_W = 3,
  parameter logic [PHY_W-1:0] WIN_BASE = 5'h10,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10
) (
  input  logic             valid,
  input  logic             write,
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] regn,
  output acc_e             acc
);
  localparam int TAG_W = PHY_W - WIN_LO_W;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[PHY_W-1:WIN_LO_W];

  logic in_win;
  logic is_page;

  assign in_win  = (phy[PHY_W-1:WIN_LO_W] == WIN_TAG);
  assign is_page = (phy == PAGE_PHY) && (regn == PAGE_REG);

  always_comb begin
    acc = ACC_NONE;
    if (valid) begin
      if (is_page) begin
        acc = write ? ACC_PAGE_WR : ACC_PAGE_RD;
      end else if (in_win) begin
        if (regn[0]) acc = write ? ACC_HI_WR : ACC_HI_RD;
        else         acc = write ? ACC_LO_WR : ACC_LO_RD;
      end
    end
  end
endmodule

// File: rtl/mdb_stage.sv
module mdb_stage
  import mdb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic [HALF_W-1:0] wdata,
  input  logic [HALF_W-1:0] rd_upper,
  output logic [PAGE_W-1:0] page_q,
  output logic [HALF_W-1:0] wr_hi_q,
  output logic [HALF_W-1:0] rd_hi_q
);
  logic              page_en, wr_hi_en, rd_hi_en;
  logic [PAGE_W-1:0] page_d;
  logic [HALF_W-1:0] wr_hi_d, rd_hi_d;

  always_comb begin
    page_en  = (acc == ACC_PAGE_WR);
    wr_hi_en = (acc == ACC_HI_WR);
    rd_hi_en = (acc == ACC_LO_RD);
    page_d   = wdata[PAGE_W-1:0];
    wr_hi_d  = wdata;
    rd_hi_d  = rd_upper;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      wr_hi_q <= '0;
      rd_hi_q <= '0;
    end else begin
      if (page_en)  page_q  <= page_d;
      if (wr_hi_en) wr_hi_q <= wr_hi_d;
      if (rd_hi_en) rd_hi_q <= rd_hi_d;
    end
  end
endmodule

// File: rtl/mdb_resp.sv
module mdb_resp
  import mdb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_e              acc,
  input  logic [HALF_W-1:0] rd_lower,
  input  logic [HALF_W-1:0] rd_hi_q,
  input  logic [PAGE_W-1:0] page_q,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data
);
  logic              vld_d;
  logic [HALF_W-1:0] data_d;

  always_comb begin
    vld_d  = 1'b0;
    data_d = rsp_data;
    case (acc)
      ACC_LO_RD:   begin vld_d = 1'b1; data_d = rd_lower; end
      ACC_HI_RD:   begin vld_d = 1'b1; data_d = rd_hi_q;  end
      ACC_PAGE_RD: begin
        vld_d  = 1'b1;
        data_d = '0;
        data_d[PAGE_W-1:0] = page_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= vld_d;
      if (vld_d) rsp_data <= data_d;
    end
  end
endmodule

// File: rtl/mdio_regbridge.sv
module mdio_regbridge
  import mdb_pkg::*;
#(
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int WIN_LO_W = 3,
  parameter int PAGE_W   = 9,
  parameter int HALF_W   = 16,
  parameter logic [PHY_W-1:0] WIN_BASE = 5'h10,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  localparam int ADDR_W = PAGE_W + WIN_LO_W + REG_W - 1,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_valid,
  input  logic              txn_write,
  input  logic [PHY_W-1:0]  txn_phy,
  input  logic [REG_W-1:0]  txn_reg,
  input  logic [HALF_W-1:0] txn_wdata,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  acc_e              acc;
  logic [PAGE_W-1:0] page_q;
  logic [HALF_W-1:0] wr_hi_q, rd_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mdb_decode #(
    .PHY_W(PHY_W), .REG_W(REG_W), .WIN_LO_W(WIN_LO_W),
    .WIN_BASE(WIN_BASE), .PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG)
  ) u_dec (
    .valid(txn_valid), .write(txn_write), .phy(txn_phy),
    .regn(txn_reg), .acc(acc)
  );

  mdb_stage #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_stage (
    .clk(clk), .rst_n(rst_sync_n), .acc(acc), .wdata(txn_wdata),
    .rd_upper(bus_rdata[WORD_W-1:HALF_W]),
    .page_q(page_q), .wr_hi_q(wr_hi_q), .rd_hi_q(rd_hi_q)
  );

  mdb_resp #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_resp (
    .clk(clk), .rst_n(rst_sync_n), .acc(acc),
    .rd_lower(bus_rdata[HALF_W-1:0]), .rd_hi_q(rd_hi_q),
    .page_q(page_q), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always_comb begin
    bus_req   = (acc == ACC_LO_WR) || (acc == ACC_LO_RD);
    bus_we    = (acc == ACC_LO_WR);
    bus_addr  = {page_q, txn_phy[WIN_LO_W-1:0], txn_reg[REG_W-1:1]};
    bus_wdata = {wr_hi_q, txn_wdata};
  end
endmodule

// File: rtl/mdio_regbridge_chk.sv
module mdio_regbridge_chk #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_valid,
  input logic              txn_write,
  input logic [PHY_W-1:0]  txn_phy,
  input logic [REG_W-1:0]  txn_reg,
  input logic              rsp_valid,
  input logic              bus_req,
  input logic              bus_we
);
  logic in_win;
  assign in_win = (txn_phy[PHY_W-1:PHY_W-2] == 2'b10);

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |-> !bus_req); // R1
  AST_HI_WR_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_write && in_win && txn_reg[0]) |-> !bus_req); // R4
  AST_LO_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_write && in_win && !txn_reg[0]) |-> (bus_req && bus_we)); // R5
  AST_LO_RD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_write && in_win && !txn_reg[0]) |-> (bus_req && !bus_we)); // R6
  AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_write && in_win) |=> rsp_valid); // R6
  AST_HI_RD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_write && in_win && txn_reg[0]) |-> !bus_req); // R7
  AST_OUT_WIN_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !in_win) |-> !bus_req); // R8
  AST_RSP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(txn_valid && !txn_write)); // R8
endmodule

bind mdio_regbridge mdio_regbridge_chk #(
  .PHY_W(PHY_W), .REG_W(REG_W), .HALF_W(HALF_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .txn_valid(txn_valid),
  .txn_write(txn_write), .txn_phy(txn_phy), .txn_reg(txn_reg),
  .rsp_valid(rsp_valid), .bus_req(bus_req), .bus_we(bus_we)
);

// File: tb/sim_mdio_regbridge.sv
module sim_mdio_regbridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_valid = 1'b0, txn_write = 1'b0;
  logic [4:0]  txn_phy = '0, txn_reg = '0;
  logic [15:0] txn_wdata = '0;
  logic        rsp_valid, bus_req, bus_we;
  logic [15:0] rsp_data, bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  logic [31:0] mem [0:63];
  int          bus_cnt = 0;
  logic [15:0] last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic        poke_en = 1'b0;
  logic [5:0]  poke_addr = '0;
  logic [31:0] poke_data = '0;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_regbridge u0 (
    .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_write(txn_write),
    .txn_phy(txn_phy), .txn_reg(txn_reg), .txn_wdata(txn_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  assign bus_rdata = mem[bus_addr[5:0]];

  always @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    if (bus_req) begin
      bus_cnt    <= bus_cnt + 1;
      last_addr  <= bus_addr;
      last_wdata <= bus_wdata;
      if (bus_we) mem[bus_addr[5:0]] <= bus_wdata;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(bit wr, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    @(negedge clk);
    txn_valid = 1'b1; txn_write = wr; txn_phy = phy; txn_reg = rg; txn_wdata = d;
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  task automatic poke(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 bus_req", {31'b0, bus_req}, 32'h0);
    txn(1'b0, 5'h1F, 5'h10, 16'h0);
    chk("R1 page after reset", {16'h0, rsp_data}, 32'h0);
  endtask

  task automatic t_page_write_map;
    int c0;
    c0 = bus_cnt;
    txn(1'b1, 5'h1F, 5'h10, 16'hFD55);
    chk("R2 no bus on page write", bus_cnt, c0);
    chk("R2 no rsp on page write", {31'b0, rsp_valid}, 32'h0);
    txn(1'b0, 5'h1F, 5'h10, 16'h0);
    chk("R9 page read valid", {31'b0, rsp_valid}, 32'h1);
    chk("R9 page read data", {16'h0, rsp_data}, 32'h0155);
    chk("R9 no bus on page read", bus_cnt, c0);
  endtask

  task automatic t_write_pair;
    int c0;
    c0 = bus_cnt;
    txn(1'b1, 5'h13, 5'h0B, 16'hABCD);
    chk("R4 odd write no bus", bus_cnt, c0);
    txn(1'b1, 5'h13, 5'h0A, 16'h1234);
    chk("R5 even write one bus cycle", bus_cnt, c0 + 1);
    chk("R3 address map", {16'h0, last_addr}, {16'h0, 9'h155, 3'b011, 4'b0101});
    chk("R5 committed word", last_wdata, 32'hABCD1234);
    txn(1'b1, 5'h13, 5'h0A, 16'h5678);
    chk("R11 staged half reused", last_wdata, 32'hABCD5678);
  endtask

  task automatic t_read_pair;
    int c0;
    c0 = bus_cnt;
    txn(1'b0, 5'h13, 5'h0A, 16'h0);
    chk("R6 lo read valid", {31'b0, rsp_valid}, 32'h1);
    chk("R6 lo read data", {16'h0, rsp_data}, 32'h5678);
    chk("R6 one bus read", bus_cnt, c0 + 1);
    poke(6'd53, 32'hFFFF0000);
    txn(1'b0, 5'h13, 5'h0B, 16'h0);
    chk("R7 hi read valid", {31'b0, rsp_valid}, 32'h1);
    chk("R7 hi read coherent", {16'h0, rsp_data}, 32'hABCD);
    chk("R7 no bus on hi read", bus_cnt, c0 + 1);
  endtask

  task automatic t_page_zero_map;
    txn(1'b1, 5'h1F, 5'h10, 16'h0000);
    poke(6'd0, 32'h0BAD_F00D);
    txn(1'b0, 5'h10, 5'h00, 16'h0);
    chk("R3 page0 addr", {16'h0, last_addr}, 32'h0);
    chk("R6 page0 data", {16'h0, rsp_data}, 32'hF00D);
    txn(1'b1, 5'h1F, 5'h10, 16'h0155);
  endtask

  task automatic t_ignored;
    int c0;
    c0 = bus_cnt;
    txn(1'b1, 5'h08, 5'h01, 16'h1111);
    txn(1'b1, 5'h18, 5'h00, 16'h2222);
    chk("R8 out-of-window writes no bus", bus_cnt, c0);
    txn(1'b0, 5'h08, 5'h00, 16'h0);
    chk("R8 out-of-window read no rsp", {31'b0, rsp_valid}, 32'h0);
    txn(1'b1, 5'h1F, 5'h11, 16'h0000);
    txn(1'b0, 5'h1F, 5'h11, 16'h0);
    chk("R10 other reg no rsp", {31'b0, rsp_valid}, 32'h0);
    txn(1'b0, 5'h1F, 5'h10, 16'h0);
    chk("R10 page unchanged", {16'h0, rsp_data}, 32'h0155);
    txn(1'b1, 5'h13, 5'h0A, 16'h9999);
    chk("R8 staged half untouched", last_wdata, 32'hABCD9999);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_page_write_map;
    t_write_pair;
    t_read_pair;
    t_page_zero_map;
    t_ignored;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule